// File: doc/BRIEF.md
# Frame DMA Channel Arbiter

This block decides which of eight DMA channels may use a shared frame data path. Channels 0 to 5 move frames from memory toward the switch (injection). Channel 6 moves frames from CPU port 0 toward memory and channel 7 does the same for CPU port 1 (extraction). Each injection channel is tied to one of the two CPU ports by a configuration bit.

Every channel presents a request. The channel that owns the path marks the last beat of its frame with an end-of-frame flag on a valid transfer. The arbiter returns a registered one-hot grant and the CPU port that the granted frame belongs to. A grant is never taken away in the middle of a frame. Between frames the two CPU ports take turns when both have work. Inside one port, extraction comes before injection, and a higher channel number comes before a lower one.

Top module: `dma_chan_arb`

## Requirements
- R1: While reset is asserted, and until the first decision after reset, `gnt_o` is all zeros and `gnt_port_o` is 0.
- R2: Channel 6 belongs to CPU port 0 and channel 7 to CPU port 1. Injection channel c belongs to the port given by bit c of `inj_port_i` (0 = port 0, 1 = port 1). `gnt_port_o` reports the port of the granted channel.
- R3: Within the port being served, a requesting extraction channel is granted ahead of every injection channel.
- R4: Within the port being served, and among injection channels, the highest-numbered requesting channel is granted.
- R5: Once granted, a channel keeps the grant until a cycle in which `xfer_i` is 1 and its own bit of `eof_i` is 1. Dropping its request does not release the grant. An end-of-frame flag from any other channel, or one without `xfer_i`, is ignored.
- R6: Decisions are made when the grant is empty or in the cycle a frame ends. A decision uses the requests of that cycle and shows on the outputs one cycle later. Only a requesting channel can be granted, so frames can follow each other back to back.
- R7: If both ports have a request at a decision, the port that did not receive the previous grant wins. Port 0 is preferred at the first decision after reset. If only one port has a request, that port is served.
- R8: A change to `inj_port_i` while a frame is in progress does not change `gnt_port_o` for that frame. The new value is used at the channel's next frame start.
- R9: `gnt_o` has at most one bit set. It becomes all zeros one cycle after a decision at which no request is present. `gnt_port_o` keeps its last value while the grant is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_i | input | N_INJ+2 | Per-channel request |
| xfer_i | input | 1 | A data beat moves on the shared path this cycle |
| eof_i | input | N_INJ+2 | Per-channel end-of-frame flag |
| inj_port_i | input | N_INJ | Per-injection-channel CPU port assignment |
| gnt_o | output | N_INJ+2 | One-hot grant, registered |
| gnt_port_o | output | 1 | CPU port of the granted frame |

## Verification
The bench targets three kinds of frame boundary. The first is an end-of-frame flag raised by a channel that does not own the path, or raised without a transfer; a design that honoured it would cut a frame short. The second is a request withdrawn mid-frame; a design that released the grant on it would hand the path over early. The third is a configuration bit flipped during a frame; a design that read it live would report the wrong port partway through the frame. Alternating request patterns across both ports check fairness: a design that used plain priority would starve port 0 whenever port 1 has extraction work. Frames that end with nothing pending check that the grant drops to zero rather than lingering.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  typedef enum logic {
    CPU_PORT0 = 1'b0,
    CPU_PORT1 = 1'b1
  } cpu_port_e;

  localparam int unsigned EXT_CHANS = 2;
endpackage

// File: rtl/dma_arb_port_map.sv
module dma_arb_port_map #(
  parameter int unsigned N_INJ = 6,
  localparam int unsigned NCH = N_INJ + dma_arb_pkg::EXT_CHANS
) (
  input  logic [NCH-1:0]   req_i,
  input  logic [N_INJ-1:0] inj_port_i,
  output logic [NCH-1:0]   req_p0_o,
  output logic [NCH-1:0]   req_p1_o
);
  logic [NCH-1:0] ch_port;

  // Port membership of every channel: injection from config, extraction fixed.
  for (genvar c = 0; c < NCH; c++) begin : g_map
    if (c < N_INJ) begin : g_inj
      assign ch_port[c] = inj_port_i[c];
    end else if (c == N_INJ) begin : g_ext0
      assign ch_port[c] = dma_arb_pkg::CPU_PORT0;
    end else begin : g_ext1
      assign ch_port[c] = dma_arb_pkg::CPU_PORT1;
    end
  end

  assign req_p0_o = req_i & ~ch_port;
  assign req_p1_o = req_i &  ch_port;
endmodule

// File: rtl/dma_arb_hi_pick.sv
module dma_arb_hi_pick #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] vec_i,
  output logic [W-1:0] onehot_o,
  output logic         any_o
);
  // Highest index wins. Extraction channels carry the top indices, so
  // this single scan orders extraction above injection as well.
  always_comb begin
    onehot_o = '0;
    any_o    = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i] && !any_o) begin
        onehot_o[i] = 1'b1;
        any_o       = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma_arb_fair_sel.sv
module dma_arb_fair_sel (
  input  logic any_p0_i,
  input  logic any_p1_i,
  input  logic pref_i,
  output logic sel_port_o,
  output logic sel_any_o
);
  always_comb begin
    sel_any_o = any_p0_i | any_p1_i;
    if (pref_i == dma_arb_pkg::CPU_PORT1) begin
      sel_port_o = any_p1_i ? dma_arb_pkg::CPU_PORT1 : dma_arb_pkg::CPU_PORT0;
    end else begin
      sel_port_o = any_p0_i ? dma_arb_pkg::CPU_PORT0 : dma_arb_pkg::CPU_PORT1;
    end
  end
endmodule

// File: rtl/dma_chan_arb.sv
module dma_chan_arb #(
  parameter int unsigned N_INJ = 6,
  localparam int unsigned NCH = N_INJ + dma_arb_pkg::EXT_CHANS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   req_i,
  input  logic             xfer_i,
  input  logic [NCH-1:0]   eof_i,
  input  logic [N_INJ-1:0] inj_port_i,
  output logic [NCH-1:0]   gnt_o,
  output logic             gnt_port_o
);
  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // Request split per port
  logic [NCH-1:0] req_p0, req_p1;
  logic [NCH-1:0] pick_p0, pick_p1;
  logic           any_p0, any_p1;

  dma_arb_port_map #(.N_INJ(N_INJ)) u_map (
    .req_i      (req_i),
    .inj_port_i (inj_port_i),
    .req_p0_o   (req_p0),
    .req_p1_o   (req_p1)
  );

  dma_arb_hi_pick #(.W(NCH)) u_pick0 (
    .vec_i(req_p0), .onehot_o(pick_p0), .any_o(any_p0)
  );

  dma_arb_hi_pick #(.W(NCH)) u_pick1 (
    .vec_i(req_p1), .onehot_o(pick_p1), .any_o(any_p1)
  );

  // State
  logic [NCH-1:0] gnt_q, gnt_d;
  logic           port_q, port_d;
  logic           pref_q, pref_d;
  logic           sel_port, sel_any;
  logic           frame_end, decide;

  dma_arb_fair_sel u_fair (
    .any_p0_i  (any_p0),
    .any_p1_i  (any_p1),
    .pref_i    (pref_q),
    .sel_port_o(sel_port),
    .sel_any_o (sel_any)
  );

  assign frame_end = xfer_i && (|(eof_i & gnt_q));
  assign decide    = (gnt_q == '0) || frame_end;

  // Next state
  always_comb begin
    gnt_d  = gnt_q;
    port_d = port_q;
    pref_d = pref_q;
    if (sel_any) begin
      gnt_d  = (sel_port == dma_arb_pkg::CPU_PORT1) ? pick_p1 : pick_p0;
      port_d = sel_port;
      pref_d = ~sel_port;
    end else begin
      gnt_d  = '0;
    end
  end

  // Registers, enabled at decision points only
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      gnt_q  <= '0;
      port_q <= dma_arb_pkg::CPU_PORT0;
      pref_q <= dma_arb_pkg::CPU_PORT0;
    end else if (decide) begin
      gnt_q  <= gnt_d;
      port_q <= port_d;
      pref_q <= pref_d;
    end
  end

  assign gnt_o      = gnt_q;
  assign gnt_port_o = port_q;
endmodule

// File: rtl/dma_chan_arb_chk.sv
module dma_chan_arb_chk #(
  parameter int unsigned N_INJ = 6,
  localparam int unsigned NCH = N_INJ + dma_arb_pkg::EXT_CHANS
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NCH-1:0]   req_i,
  input logic             xfer_i,
  input logic [NCH-1:0]   eof_i,
  input logic [NCH-1:0]   gnt_o,
  input logic             gnt_port_o
);
  logic fe, mid;
  assign fe  = xfer_i && (|(eof_i & gnt_o));
  assign mid = (|gnt_o) && !fe;

  // R9
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_o));

  // R5
  gnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mid |=> (gnt_o == $past(gnt_o)));

  // R8
  port_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mid |=> $stable(gnt_port_o));

  // R2
  ext1_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_o[NCH-1] |-> gnt_port_o);

  // R2
  ext0_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_o[NCH-2] |-> !gnt_port_o);

  // R9
  idle_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (((gnt_o == '0) || fe) && (req_i == '0)) |=> (gnt_o == '0));

  // R6
  gnt_from_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((gnt_o == '0) || fe) |=> ((gnt_o & ~$past(req_i)) == '0));
endmodule

bind dma_chan_arb dma_chan_arb_chk #(.N_INJ(N_INJ)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_i      (req_i),
  .xfer_i     (xfer_i),
  .eof_i      (eof_i),
  .gnt_o      (gnt_o),
  .gnt_port_o (gnt_port_o)
);

// File: tb/test_dma_chan_arb.sv
module test_dma_chan_arb;
  logic       clk;
  logic       rst_n;
  logic [7:0] req;
  logic       xfer;
  logic [7:0] eof;
  logic [5:0] cfg;
  logic [7:0] gnt;
  logic       gport;

  int n_chk;
  int n_bad;

  // Reference state
  logic [7:0] m_gnt;
  logic       m_port;
  logic       m_pref;

  dma_chan_arb i_dma_chan_arb (
    .clk(clk), .rst_n(rst_n), .req_i(req), .xfer_i(xfer), .eof_i(eof),
    .inj_port_i(cfg), .gnt_o(gnt), .gnt_port_o(gport)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog: run did not finish, got running expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  // Best channel of one port: extraction first, then injection high to low.
  function automatic logic [7:0] best_of(input logic [7:0] rq, input logic [5:0] cf,
                                         input logic p);
    logic [7:0] r;
    int ext;
    r = 8'h00;
    ext = p ? 7 : 6;
    if (rq[ext]) r[ext] = 1'b1;
    else begin
      for (int c = 5; c >= 0; c--) begin
        if (r == 8'h00 && rq[c] && cf[c] == p) r[c] = 1'b1;
      end
    end
    return r;
  endfunction

  task automatic model_edge(input logic [7:0] rq, input logic x,
                            input logic [7:0] eo, input logic [5:0] cf);
    logic [7:0] a0, a1;
    logic pp;
    if (m_gnt == 8'h00 || (x && (eo & m_gnt) != 8'h00)) begin
      a0 = best_of(rq, cf, 1'b0);
      a1 = best_of(rq, cf, 1'b1);
      if (a0 != 0 || a1 != 0) begin
        if (a0 != 0 && a1 != 0) pp = m_pref;
        else pp = (a1 != 0);
        m_gnt  = pp ? a1 : a0;
        m_port = pp;
        m_pref = ~pp;
      end else begin
        m_gnt = 8'h00;
      end
    end
  endtask

  task automatic check(input string tag);
    n_chk++;
    if (gnt !== m_gnt || gport !== m_port) begin
      n_bad++;
      $display("FAIL %s: gnt=%b port=%b expected gnt=%b port=%b at %0t",
               tag, gnt, gport, m_gnt, m_port, $time);
    end
  endtask

  // Drive after a falling edge, model the rising edge, compare at next fall.
  task automatic cyc(input logic [7:0] rq, input logic x, input logic [7:0] eo,
                     input logic [5:0] cf, input string tag);
    req = rq; xfer = x; eof = eo; cfg = cf;
    @(posedge clk);
    model_edge(rq, x, eo, cf);
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    int sd;
    logic [7:0] rq, eo;
    logic [5:0] cf;
    n_chk = 0; n_bad = 0;
    m_gnt = 0; m_port = 0; m_pref = 0;
    req = 0; xfer = 0; eof = 0; cfg = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset");
    rst_n = 1'b1;
    repeat (3) cyc(8'h00, 1'b0, 8'h00, 6'h00, "R1 after release");

    // R3: extraction 6 over injection 5 on port 0
    cyc(8'h60, 1'b0, 8'h00, 6'h00, "R3 ext over inj");
    // R6: back-to-back, channel 6 ends, channel 5 follows
    cyc(8'h20, 1'b1, 8'h40, 6'h00, "R6 back-to-back");
    // R4: channel 5 ends, channels 2 and 4 pending
    cyc(8'h14, 1'b1, 8'h20, 6'h00, "R4 higher number");
    // R5: request dropped, foreign eof, eof without transfer
    cyc(8'h00, 1'b0, 8'h00, 6'h00, "R5 drop request");
    cyc(8'h01, 1'b1, 8'h05, 6'h00, "R5 foreign eof");
    cyc(8'h01, 1'b0, 8'h10, 6'h00, "R5 eof without xfer");
    // R8: port bit of owner flips mid-frame
    cyc(8'h00, 1'b1, 8'h00, 6'h10, "R8 cfg mid-frame");
    cyc(8'h00, 1'b0, 8'h00, 6'h10, "R8 cfg mid-frame");
    // R9: frame ends, nothing pending
    cyc(8'h00, 1'b1, 8'h10, 6'h10, "R9 idle drop");
    cyc(8'h00, 1'b0, 8'h00, 6'h10, "R9 stays idle");
    // R8: channel 4 now starts on port 1
    cyc(8'h10, 1'b0, 8'h00, 6'h10, "R8 new cfg at start");
    cyc(8'h00, 1'b1, 8'h10, 6'h10, "R9 idle drop");
    // R7: port 0 (ch1) and port 1 (ch4) both busy, one-beat frames
    for (int k = 0; k < 8; k++) begin
      cyc(8'h12, 1'b1, 8'h12, 6'h38, "R7 alternation");
    end
    cyc(8'h00, 1'b1, 8'hFF, 6'h38, "R9 idle drop");
    // R2: extraction 7 reports port 1
    cyc(8'h80, 1'b0, 8'h00, 6'h00, "R2 ext port 1");
    cyc(8'h00, 1'b1, 8'h80, 6'h00, "R9 idle drop");

    // Random phase
    sd = $urandom(24681);
    cf = 6'h15;
    for (int k = 0; k < 4000; k++) begin
      if ($urandom % 64 == 0) cf = 6'($urandom);
      rq = 8'($urandom) & 8'($urandom);
      eo = ($urandom % 3 == 0) ? 8'($urandom) : 8'h00;
      cyc(rq, 1'($urandom), eo, cf, "R2/R3/R4/R5/R6/R7/R8/R9 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule